// File: doc/BRIEF.md
# Exception Cause Capture Unit

This unit sits beside the load/store path and the fetch path of a 32-bit soft processor. It records why the last exception happened and where. On every cycle it looks at the current data access. If the address bits selected by the size mask are not all zero, it writes the access address into the address register. In the same cycle it writes a cause word into the status register. The cause word holds the misalignment code, the target register index, the direction and whether the access was a full word.

The unit also takes bus-error strobes from the instruction side and the data side, each with its own address. A bus error is considered only while the global exception-enable input is high. It then records its address, but it writes its cause code and raises a trap only when the enable for that source is also high. Every capture is registered. A trap request leaves the unit as a single-cycle pulse one clock after the event that caused it. When more than one source fires in the same cycle, the misaligned access wins, then the instruction bus, then the data bus.

The trap pulse comes from a small state machine with two states. `ST_IDLE` means no trap is being signalled. `ST_TRAP` drives the pulse. The transitions are:
- IDLE_TO_TRAP: a trap-worthy event is seen in `ST_IDLE`.
- TRAP_TO_TRAP: a new trap-worthy event is seen while the pulse is high, so back-to-back events give one pulse cycle each.
- TRAP_TO_IDLE: no new event is seen in `ST_TRAP`.
- IDLE_HOLD: `ST_IDLE` stays put when nothing happens.

Top module: `exc_capture`

## Requirements
- R1: A data access counts as misaligned only when `acc_valid` is 1 and (`acc_addr` low bits AND `acc_mask`) is nonzero. An aligned access, or any access with mask 0, leaves both registers and the trap unchanged.
- R2: On a misaligned access, `ear_q` takes `acc_addr` on the next clock edge.
- R3: On a misaligned access, `esr_q` becomes a word with the following fields; all other bits are 0 except bit 11 (see R4):
  - bits 4:0 hold cause code 1;
  - bits 9:5 hold `acc_dreg`;
  - bit 10 holds `acc_write`.
- R4: In the misaligned status word, bit 11 is 1 exactly when `acc_mask` equals 3, which marks a word access.
- R5: A misaligned access updates both registers whatever `exc_en` is, but it raises the trap only when `exc_en` is 1.
- R6: While `exc_en` is 0, bus errors change neither register and raise no trap.
- R7: While `exc_en` is 1, a bus error writes its own address into `ear_q`, even when the enable for that source is 0.
- R8: With `exc_en` and `ibus_exc_en` both 1, an instruction bus error sets `esr_q` to cause code 3 (other bits 0) and raises the trap. With `ibus_exc_en` at 0, `esr_q` is left unchanged and no trap is raised.
- R9: With `exc_en` and `dbus_exc_en` both 1, a data bus error sets `esr_q` to cause code 4 (other bits 0) and raises the trap. With `dbus_exc_en` at 0, `esr_q` is left unchanged and no trap is raised.
- R10: When several sources fire in one cycle, only the highest-priority one takes effect. The order is misaligned access, then instruction bus error, then data bus error; a lower source has no effect that cycle.
- R11: `trap_o` goes high for exactly one cycle, one clock after each trap-worthy event. Events in consecutive cycles give consecutive pulse cycles.
- R12: A synchronous reset clears `ear_q`, `esr_q` and `trap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Data access presented this cycle |
| acc_addr | input | ADDR_W | Data access address |
| acc_mask | input | MASK_W | Alignment mask (0 byte, 1 half, 3 word) |
| acc_write | input | 1 | Access is a store |
| acc_dreg | input | RIDX_W | Destination/source register index |
| ibus_err | input | 1 | Instruction bus error strobe |
| ibus_addr | input | ADDR_W | Address of the failing fetch |
| dbus_err | input | 1 | Data bus error strobe |
| dbus_addr | input | ADDR_W | Address of the failing data transfer |
| exc_en | input | 1 | Global exception enable |
| ibus_exc_en | input | 1 | Enable for instruction bus error exceptions |
| dbus_exc_en | input | 1 | Enable for data bus error exceptions |
| ear_q | output | ADDR_W | Captured exception address |
| esr_q | output | STAT_W | Captured exception status word |
| trap_o | output | 1 | One-cycle hardware exception request |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 2-bit mask whose all-ones value (3) is the word size, a 5-bit register index and a 32-bit status word. With these values every field of the status word can be observed. The word-size bit is reached with mask 3, and the register index field is tested at its top value of 31. Halfword, byte and word masks are all exercised, together with every combination of the global and per-source enables and with three sources colliding in one cycle.

// File: rtl/exc_cause_pkg.sv
package exc_cause_pkg;

    // cause code field sits in the low bits of the status word
    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CAUSE_MISALIGN = 5'd1;
    localparam logic [CODE_W-1:0] CAUSE_IBUS     = 5'd3;
    localparam logic [CODE_W-1:0] CAUSE_DBUS     = 5'd4;

    // field positions inside the misalignment status word
    localparam int DREG_LSB  = 5;
    localparam int WRITE_BIT = 10;
    localparam int SIZE_BIT  = 11;

    // bus error channels, index order is also priority order
    localparam int BUS_CH   = 2;
    localparam int CH_IBUS  = 0;
    localparam int CH_DBUS  = 1;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ALIGN,
        SRC_BUS
    } cap_src_e;

    typedef enum logic {
        ST_IDLE,
        ST_TRAP
    } trap_state_e;

endpackage

// File: rtl/exc_align_chk.sv
module exc_align_chk
    import exc_cause_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2,
    parameter int RIDX_W = 5,
    parameter int STAT_W = 32,
    parameter logic [MASK_W-1:0] WORD_MASK = '1
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic              acc_write,
    input  logic [RIDX_W-1:0] acc_dreg,
    output logic              mis_o,
    output logic [STAT_W-1:0] stat_o
);

    logic [MASK_W-1:0] low_sel;
    logic              is_word;

    always_comb begin
        low_sel = acc_addr[MASK_W-1:0] & acc_mask;
        mis_o   = acc_valid && (low_sel != '0);
        is_word = (acc_mask == WORD_MASK);
    end

    always_comb begin
        stat_o = '0;
        stat_o[CODE_W-1:0]            = CAUSE_MISALIGN;
        stat_o[DREG_LSB +: RIDX_W]    = acc_dreg;
        stat_o[WRITE_BIT]             = acc_write;
        stat_o[SIZE_BIT]              = is_word;
    end

endmodule

// File: rtl/exc_bus_gate.sv
module exc_bus_gate
    import exc_cause_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 32
) (
    input  logic                           exc_en,
    input  logic [BUS_CH-1:0]              err_i,
    input  logic [BUS_CH-1:0][ADDR_W-1:0]  addr_i,
    input  logic [BUS_CH-1:0]              src_en_i,
    output logic                           rec_o,
    output logic [ADDR_W-1:0]              rec_addr_o,
    output logic                           raise_o,
    output logic [STAT_W-1:0]              stat_o
);

    logic [BUS_CH-1:0]              rec_ch;
    logic [BUS_CH-1:0]              raise_ch;
    logic [BUS_CH-1:0][STAT_W-1:0]  stat_ch;

    for (genvar gi = 0; gi < BUS_CH; gi++) begin : g_ch
        localparam logic [CODE_W-1:0] CH_CODE =
            (gi == CH_IBUS) ? CAUSE_IBUS : CAUSE_DBUS;
        always_comb begin
            rec_ch[gi]   = err_i[gi] && exc_en;
            raise_ch[gi] = rec_ch[gi] && src_en_i[gi];
            stat_ch[gi]  = '0;
            stat_ch[gi][CODE_W-1:0] = CH_CODE;
        end
    end

    // lowest channel index wins
    always_comb begin
        rec_o      = 1'b0;
        rec_addr_o = '0;
        raise_o    = 1'b0;
        stat_o     = '0;
        for (int i = BUS_CH - 1; i >= 0; i--) begin
            if (rec_ch[i]) begin
                rec_o      = 1'b1;
                rec_addr_o = addr_i[i];
                raise_o    = raise_ch[i];
                stat_o     = stat_ch[i];
            end
        end
    end

endmodule

// File: rtl/exc_cause_fsm.sv
module exc_cause_fsm
    import exc_cause_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mis_i,
    input  logic [ADDR_W-1:0] mis_addr_i,
    input  logic [STAT_W-1:0] mis_stat_i,
    input  logic              exc_en,
    input  logic              bus_rec_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_raise_i,
    input  logic [STAT_W-1:0] bus_stat_i,
    output logic [ADDR_W-1:0] ear_q,
    output logic [STAT_W-1:0] esr_q,
    output logic              trap_o
);

    cap_src_e    src;
    trap_state_e state_q, state_nx;
    logic              ear_we, esr_we, trap_req;
    logic [ADDR_W-1:0] ear_d;
    logic [STAT_W-1:0] esr_d;

    // source selection: misaligned access beats any bus error
    always_comb begin
        if (mis_i)          src = SRC_ALIGN;
        else if (bus_rec_i) src = SRC_BUS;
        else                src = SRC_NONE;
    end

    always_comb begin
        ear_we   = 1'b0;
        esr_we   = 1'b0;
        trap_req = 1'b0;
        ear_d    = '0;
        esr_d    = '0;
        unique case (src)
            SRC_ALIGN: begin
                ear_we   = 1'b1;
                esr_we   = 1'b1;
                ear_d    = mis_addr_i;
                esr_d    = mis_stat_i;
                trap_req = exc_en;
            end
            SRC_BUS: begin
                ear_we   = 1'b1;
                ear_d    = bus_addr_i;
                esr_we   = bus_raise_i;
                esr_d    = bus_stat_i;
                trap_req = bus_raise_i;
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // transitions: IDLE_TO_TRAP, IDLE_HOLD, TRAP_TO_TRAP, TRAP_TO_IDLE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = trap_req ? ST_TRAP : ST_IDLE;
            ST_TRAP: state_nx = trap_req ? ST_TRAP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trap_o = 1'b0;
        unique case (state_q)
            ST_TRAP: trap_o = 1'b1;
            default: trap_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ear_q <= '0;
            esr_q <= '0;
        end else begin
            if (ear_we) ear_q <= ear_d;
            if (esr_we) esr_q <= esr_d;
        end
    end

endmodule

// File: rtl/exc_capture.sv
module exc_capture
    import exc_cause_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2,
    parameter int RIDX_W = 5,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic              acc_write,
    input  logic [RIDX_W-1:0] acc_dreg,
    input  logic              ibus_err,
    input  logic [ADDR_W-1:0] ibus_addr,
    input  logic              dbus_err,
    input  logic [ADDR_W-1:0] dbus_addr,
    input  logic              exc_en,
    input  logic              ibus_exc_en,
    input  logic              dbus_exc_en,
    output logic [ADDR_W-1:0] ear_q,
    output logic [STAT_W-1:0] esr_q,
    output logic              trap_o
);

    logic                          mis;
    logic [STAT_W-1:0]             mis_stat;
    logic [BUS_CH-1:0]             bus_err;
    logic [BUS_CH-1:0][ADDR_W-1:0] bus_addr;
    logic [BUS_CH-1:0]             bus_en;
    logic                          bus_rec, bus_raise;
    logic [ADDR_W-1:0]             bus_rec_addr;
    logic [STAT_W-1:0]             bus_stat;

    always_comb begin
        bus_err[CH_IBUS]  = ibus_err;
        bus_err[CH_DBUS]  = dbus_err;
        bus_addr[CH_IBUS] = ibus_addr;
        bus_addr[CH_DBUS] = dbus_addr;
        bus_en[CH_IBUS]   = ibus_exc_en;
        bus_en[CH_DBUS]   = dbus_exc_en;
    end

    exc_align_chk #(
        .ADDR_W(ADDR_W), .MASK_W(MASK_W), .RIDX_W(RIDX_W), .STAT_W(STAT_W)
    ) u_align (
        .acc_valid(acc_valid),
        .acc_addr (acc_addr),
        .acc_mask (acc_mask),
        .acc_write(acc_write),
        .acc_dreg (acc_dreg),
        .mis_o    (mis),
        .stat_o   (mis_stat)
    );

    exc_bus_gate #(
        .ADDR_W(ADDR_W), .STAT_W(STAT_W)
    ) u_bus (
        .exc_en    (exc_en),
        .err_i     (bus_err),
        .addr_i    (bus_addr),
        .src_en_i  (bus_en),
        .rec_o     (bus_rec),
        .rec_addr_o(bus_rec_addr),
        .raise_o   (bus_raise),
        .stat_o    (bus_stat)
    );

    exc_cause_fsm #(
        .ADDR_W(ADDR_W), .STAT_W(STAT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mis_i      (mis),
        .mis_addr_i (acc_addr),
        .mis_stat_i (mis_stat),
        .exc_en     (exc_en),
        .bus_rec_i  (bus_rec),
        .bus_addr_i (bus_rec_addr),
        .bus_raise_i(bus_raise),
        .bus_stat_i (bus_stat),
        .ear_q      (ear_q),
        .esr_q      (esr_q),
        .trap_o     (trap_o)
    );

endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk #(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 2,
    parameter int RIDX_W = 5,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [MASK_W-1:0] acc_mask,
    input logic [RIDX_W-1:0] acc_dreg,
    input logic              ibus_err,
    input logic              exc_en,
    input logic              ibus_exc_en,
    input logic [ADDR_W-1:0] ear_q,
    input logic [STAT_W-1:0] esr_q,
    input logic              trap_o
);

    logic mis_seen;
    assign mis_seen = acc_valid && ((acc_addr[MASK_W-1:0] & acc_mask) != '0);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ear_q == '0 && esr_q == '0 && !trap_o)); // R12

    AST_MIS_ADDR: assert property (@(posedge clk) disable iff (rst)
        mis_seen |=> ear_q == $past(acc_addr)); // R2

    AST_MIS_CODE: assert property (@(posedge clk) disable iff (rst)
        mis_seen |=> (esr_q[4:0] == 5'd1 && esr_q[9:5] == $past(acc_dreg))); // R3

    AST_MIS_TRAP: assert property (@(posedge clk) disable iff (rst)
        (mis_seen && exc_en) |=> trap_o); // R5

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!mis_seen && !exc_en) |=> (!trap_o && $stable(ear_q) && $stable(esr_q))); // R6

    AST_IBUS_RAISE: assert property (@(posedge clk) disable iff (rst)
        (!mis_seen && exc_en && ibus_err && ibus_exc_en) |=> (trap_o && esr_q == 32'd3)); // R8

endmodule

bind exc_capture exc_capture_chk #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W), .RIDX_W(RIDX_W), .STAT_W(STAT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_mask   (acc_mask),
    .acc_dreg   (acc_dreg),
    .ibus_err   (ibus_err),
    .exc_en     (exc_en),
    .ibus_exc_en(ibus_exc_en),
    .ear_q      (ear_q),
    .esr_q      (esr_q),
    .trap_o     (trap_o)
);

// File: tb/exc_capture_tb.sv
module exc_capture_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_mask = '0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_dreg = '0;
    logic        ibus_err = 1'b0;
    logic [31:0] ibus_addr = '0;
    logic        dbus_err = 1'b0;
    logic [31:0] dbus_addr = '0;
    logic        exc_en = 1'b0;
    logic        ibus_exc_en = 1'b0;
    logic        dbus_exc_en = 1'b0;
    logic [31:0] ear_q;
    logic [31:0] esr_q;
    logic        trap_o;

    always #5 clk = ~clk;

    exc_capture u_dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_mask(acc_mask),
        .acc_write(acc_write), .acc_dreg(acc_dreg),
        .ibus_err(ibus_err), .ibus_addr(ibus_addr),
        .dbus_err(dbus_err), .dbus_addr(dbus_addr),
        .exc_en(exc_en), .ibus_exc_en(ibus_exc_en), .dbus_exc_en(dbus_exc_en),
        .ear_q(ear_q), .esr_q(esr_q), .trap_o(trap_o)
    );

    typedef struct {
        logic [31:0] ear;
        logic [31:0] esr;
        logic        trap;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          total = 0;
    int          bad = 0;
    logic [31:0] m_ear = '0;
    logic [31:0] m_esr = '0;
    bit          done = 1'b0;

    // monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (ear_q !== e.ear || esr_q !== e.esr || trap_o !== e.trap) begin
                    bad++;
                    $display("FAIL %s: ear=%h esr=%h trap=%b expected ear=%h esr=%h trap=%b",
                             e.tag, ear_q, esr_q, trap_o, e.ear, e.esr, e.trap);
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        exp_t e;
        @(negedge clk);
        rst = 1'b1;
        acc_valid = 1'b0; ibus_err = 1'b0; dbus_err = 1'b0;
        m_ear = '0; m_esr = '0;
        e.ear = '0; e.esr = '0; e.trap = 1'b0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input logic v, input logic [31:0] a, input logic [1:0] m,
                        input logic w, input logic [4:0] d,
                        input logic ie, input logic [31:0] ia,
                        input logic de, input logic [31:0] da,
                        input logic ee, input logic ien, input logic den,
                        input string tag);
        exp_t e;
        logic mis;
        logic tr;
        @(negedge clk);
        rst = 1'b0;
        acc_valid = v; acc_addr = a; acc_mask = m; acc_write = w; acc_dreg = d;
        ibus_err = ie; ibus_addr = ia; dbus_err = de; dbus_addr = da;
        exc_en = ee; ibus_exc_en = ien; dbus_exc_en = den;
        mis = v && ((a[1:0] & m) != 2'b00);
        tr  = 1'b0;
        if (mis) begin
            m_ear = a;
            m_esr = 32'd1 | (32'(d) << 5) | (32'(w) << 10) | (32'(m == 2'd3) << 11);
            tr = ee;
        end else if (ee && ie) begin
            m_ear = ia;
            if (ien) begin m_esr = 32'd3; tr = 1'b1; end
        end else if (ee && de) begin
            m_ear = da;
            if (den) begin m_esr = 32'd4; tr = 1'b1; end
        end
        e.ear = m_ear; e.esr = m_esr; e.trap = tr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic ee, input string tag);
        step(1'b0, '0, 2'd0, 1'b0, 5'd0, 1'b0, '0, 1'b0, '0, ee, 1'b1, 1'b1, tag);
    endtask

    initial begin
        do_reset("R12 reset state");
        do_reset("R12 reset state");
        // R1: aligned word and byte accesses change nothing
        step(1, 32'h1000, 2'd3, 1, 5'd7, 0, '0, 0, '0, 1, 1, 1, "R1 aligned word");
        step(1, 32'h0003, 2'd0, 0, 5'd7, 0, '0, 0, '0, 1, 1, 1, "R1 byte never misaligned");
        step(0, 32'h0001, 2'd3, 0, 5'd7, 0, '0, 0, '0, 1, 1, 1, "R1 invalid access ignored");
        // R2 R3 R5: halfword store misaligned, register 31, enabled
        step(1, 32'h1001, 2'd1, 1, 5'd31, 0, '0, 0, '0, 1, 0, 0, "R2/R3/R5 half store");
        idle(1, "R11 pulse ends");
        // R4 R5: word load misaligned, exceptions disabled
        step(1, 32'h2002, 2'd3, 0, 5'd5, 0, '0, 0, '0, 0, 0, 0, "R4/R5 word load ee=0");
        // R6: bus errors with global enable off
        step(0, '0, 2'd0, 0, 5'd0, 1, 32'hAAAA_0000, 1, 32'hBBBB_0000, 0, 1, 1, "R6 bus errs ignored");
        idle(0, "R6 still quiet");
        // R7 R8: instruction bus error, source disabled
        step(0, '0, 2'd0, 0, 5'd0, 1, 32'h0040_0000, 0, '0, 1, 0, 1, "R7/R8 ibus no source en");
        // R8: enabled
        step(0, '0, 2'd0, 0, 5'd0, 1, 32'h0040_0010, 0, '0, 1, 1, 0, "R8 ibus trap");
        idle(1, "R11 after ibus");
        // R9: data bus error enabled then disabled
        step(0, '0, 2'd0, 0, 5'd0, 0, '0, 1, 32'h8000_0100, 1, 0, 1, "R9 dbus trap");
        step(0, '0, 2'd0, 0, 5'd0, 0, '0, 1, 32'h8000_0200, 1, 1, 0, "R7/R9 dbus no source en");
        // R10: all three fire, misaligned wins
        step(1, 32'h3006, 2'd3, 1, 5'd12, 1, 32'h1111_0000, 1, 32'h2222_0000, 1, 1, 1, "R10 mis wins");
        // R10: both buses, instruction bus wins
        step(0, '0, 2'd0, 0, 5'd0, 1, 32'h1111_0004, 1, 32'h2222_0004, 1, 1, 1, "R10 ibus over dbus");
        // R10: ibus recorded but gated still blocks dbus
        step(0, '0, 2'd0, 0, 5'd0, 1, 32'h1111_0008, 1, 32'h2222_0008, 1, 0, 1, "R10 gated ibus blocks dbus");
        // R11: back-to-back events
        step(1, 32'h0005, 2'd1, 0, 5'd1, 0, '0, 0, '0, 1, 0, 0, "R11 first of pair");
        step(0, '0, 2'd0, 0, 5'd0, 0, '0, 1, 32'h0000_0700, 1, 0, 1, "R11 second of pair");
        idle(1, "R11 pair ends");
        // R12: reset after activity
        step(1, 32'h0007, 2'd3, 1, 5'd9, 0, '0, 0, '0, 1, 0, 0, "R4 word store");
        do_reset("R12 mid-run reset");
        idle(1, "R12 stays clear");
        @(negedge clk);
        wait (exp_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule